// File: doc/BRIEF.md
# Single-Word Reservation Snoop Tracker

This block keeps the one reservation that a CPU holds after a load-with-reservation. It stores the word address and a valid flag, then watches writes from other masters on two internal buses. One is the local bus next to the core. The other is the remote bus, reached through a bridge. A write that lands on the reserved word ends the reservation.

The two buses are handled differently. A hit on the local bus clears the flag and also raises a one-cycle cancel pulse to the core on the next clock, so the core can drop its internal copy at once. A hit on the remote bus only clears the flag. The loss shows up later: when the CPU issues a store-conditional aimed at the remote bus and the flag is clear, the block asserts a block signal in that same cycle. The bridge then does not start the bus cycle, and the core sees the store as aborted with no side effects.

All addresses at the ports are word addresses. The byte offset inside a word never affects a match.

Top module: `rsv_snoop_tracker`

## Requirements
- R1: After hard reset (`rst_n` low) the flag, the cancel pulse and the block signal are all low. A cycle with `soft_rst` high clears the flag on the next edge, whatever else happens in that cycle.
- R2: A load-with-reservation sets the flag on the next edge, whether `cpu_lr_err` is high or low. A new load-with-reservation replaces the stored word address, so later writes to the old word have no effect.
- R3: A snooped write clears the flag on the next edge when all of these hold: its valid is high, its `*_wr_aok` (address phase ended normally) is high, its size code is 0 (byte), 1 (halfword) or 2 (word), and its word address equals the stored one. A write to a different word, or one with `*_wr_aok` low, leaves the flag set.
- R4: A snooped write with size code 3 (aligned doubleword) clears the flag when its word address matches the stored one in every bit except bit 0.
- R5: A store-conditional whose address phase ends normally (`cpu_sc_aok` high) clears the flag on the next edge. With `cpu_sc_aok` low, the flag is kept.
- R6: A plain store by the CPU (`cpu_st_valid`) never changes the flag.
- R7: A local-bus write that clears a set flag raises `cancel_rsv` for exactly the one cycle after that write. A remote-bus hit, or a local hit while the flag is already clear, raises no cancel.
- R8: `sc_block` is high in the same cycle as a store-conditional with `cpu_sc_remote` high when the flag is clear. It stays low when the flag is set, and low for a store-conditional aimed at the local bus.
- R9: When a load-with-reservation and a local-bus hit on the old word fall in the same cycle, the new reservation wins. The flag ends set and no cancel is raised.
- R10: When a remote store-conditional and a remote hit fall in the same cycle while the flag is set, the store-conditional is not blocked. The flag is clear after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset; clears the flag |
| cpu_lr_valid | input | 1 | CPU load-with-reservation in this cycle |
| cpu_lr_waddr | input | WA_W | Word address of the load-with-reservation |
| cpu_lr_err | input | 1 | Termination error on the load-with-reservation; has no effect on the reservation |
| cpu_sc_valid | input | 1 | CPU store-conditional in this cycle |
| cpu_sc_remote | input | 1 | The store-conditional targets the remote bus |
| cpu_sc_aok | input | 1 | Address phase of the store-conditional ended normally |
| cpu_st_valid | input | 1 | CPU plain store in this cycle |
| loc_wr_valid | input | 1 | Local-bus write by another master |
| loc_wr_waddr | input | WA_W | Word address of the local write |
| loc_wr_size | input | 2 | Local write size: 0 byte, 1 half, 2 word, 3 doubleword |
| loc_wr_aok | input | 1 | Local write address phase ended normally |
| rem_wr_valid | input | 1 | Remote-bus write by another master |
| rem_wr_waddr | input | WA_W | Word address of the remote write |
| rem_wr_size | input | 2 | Remote write size, same coding as the local size |
| rem_wr_aok | input | 1 | Remote write address phase ended normally |
| rsv_flag | output | 1 | Reservation is held |
| cancel_rsv | output | 1 | One-cycle cancel to the core after a local intrusion |
| sc_block | output | 1 | Do not start this store-conditional on the remote bus |

## Verification
Two pairs of events can fall in the same cycle. In the first, a new load-with-reservation coincides with a local write to the old word. In the second, a remote store-conditional coincides with a remote write to the reserved word. The bench drives each pair on the same edge. For the first pair it expects the flag set and no cancel afterwards. For the second it reads `sc_block` before the edge and expects it low, then expects the flag clear after the edge.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    // Snooped write size codes
    localparam logic [1:0] SZ_BYTE  = 2'd0;
    localparam logic [1:0] SZ_HALF  = 2'd1;
    localparam logic [1:0] SZ_WORD  = 2'd2;
    localparam logic [1:0] SZ_DWORD = 2'd3;

    // Snooped bus indices
    localparam int NUM_BUS = 2;
    localparam int BUS_LOC = 0;
    localparam int BUS_REM = 1;

    typedef struct packed {
        logic flag;
        logic cancel;
    } rsv_ctl_t;

endpackage

// File: rtl/rsv_word_match.sv
module rsv_word_match
    import rsv_pkg::*;
#(
    parameter int WA_W = 30
) (
    input  logic [WA_W-1:0] rsv_waddr,
    input  logic            wr_valid,
    input  logic            wr_aok,
    input  logic [WA_W-1:0] wr_waddr,
    input  logic [1:0]      wr_size,
    output logic            hit
);

    logic word_eq;
    logic pair_eq;
    logic addr_eq;

    always_comb begin
        word_eq = (rsv_waddr == wr_waddr);
        pair_eq = (rsv_waddr[WA_W-1:1] == wr_waddr[WA_W-1:1]);
        // a doubleword covers both words of an aligned pair
        addr_eq = (wr_size == SZ_DWORD) ? pair_eq : word_eq;
        hit     = wr_valid & wr_aok & addr_eq;
    end

endmodule

// File: rtl/rsv_snoop_tracker.sv
module rsv_snoop_tracker
    import rsv_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4,
    localparam int OFF_W     = $clog2(WORD_BYTES),
    localparam int WA_W      = ADDR_W - OFF_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_rst,
    input  logic            cpu_lr_valid,
    input  logic [WA_W-1:0] cpu_lr_waddr,
    input  logic            cpu_lr_err,
    input  logic            cpu_sc_valid,
    input  logic            cpu_sc_remote,
    input  logic            cpu_sc_aok,
    input  logic            cpu_st_valid,
    input  logic            loc_wr_valid,
    input  logic [WA_W-1:0] loc_wr_waddr,
    input  logic [1:0]      loc_wr_size,
    input  logic            loc_wr_aok,
    input  logic            rem_wr_valid,
    input  logic [WA_W-1:0] rem_wr_waddr,
    input  logic [1:0]      rem_wr_size,
    input  logic            rem_wr_aok,
    output logic            rsv_flag,
    output logic            cancel_rsv,
    output logic            sc_block
);

    logic [NUM_BUS-1:0]            snp_valid;
    logic [NUM_BUS-1:0]            snp_aok;
    logic [NUM_BUS-1:0][WA_W-1:0]  snp_waddr;
    logic [NUM_BUS-1:0][1:0]       snp_size;
    logic [NUM_BUS-1:0]            snp_hit;

    rsv_ctl_t        ctl_d, ctl_q;
    logic [WA_W-1:0] waddr_d, waddr_q;

    always_comb begin
        snp_valid[BUS_LOC] = loc_wr_valid;
        snp_aok[BUS_LOC]   = loc_wr_aok;
        snp_waddr[BUS_LOC] = loc_wr_waddr;
        snp_size[BUS_LOC]  = loc_wr_size;
        snp_valid[BUS_REM] = rem_wr_valid;
        snp_aok[BUS_REM]   = rem_wr_aok;
        snp_waddr[BUS_REM] = rem_wr_waddr;
        snp_size[BUS_REM]  = rem_wr_size;
    end

    for (genvar b = 0; b < NUM_BUS; b++) begin : g_snoop
        rsv_word_match #(.WA_W(WA_W)) u_match (
            .rsv_waddr (waddr_q),
            .wr_valid  (snp_valid[b]),
            .wr_aok    (snp_aok[b]),
            .wr_waddr  (snp_waddr[b]),
            .wr_size   (snp_size[b]),
            .hit       (snp_hit[b])
        );
    end

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.cancel = 1'b0;
        waddr_d      = waddr_q;
        if (soft_rst) begin
            ctl_d.flag = 1'b0;
        end else if (cpu_lr_valid) begin
            ctl_d.flag = 1'b1;
            waddr_d    = cpu_lr_waddr;
        end else begin
            if (cpu_sc_valid && cpu_sc_aok) ctl_d.flag = 1'b0;
            if (|snp_hit)                   ctl_d.flag = 1'b0;
            if (snp_hit[BUS_LOC] && ctl_q.flag) ctl_d.cancel = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            waddr_q <= '0;
        end else begin
            ctl_q   <= ctl_d;
            waddr_q <= waddr_d;
        end
    end

    assign rsv_flag   = ctl_q.flag;
    assign cancel_rsv = ctl_q.cancel;
    assign sc_block   = cpu_sc_valid & cpu_sc_remote & ~ctl_q.flag;

    // ---------------- assertions ----------------
    assert_soft_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !rsv_flag);

    assert_lr_despite_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_lr_valid && cpu_lr_err && !soft_rst) |=> rsv_flag);

    assert_remote_hit_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_hit[BUS_REM] && !cpu_lr_valid) |=> !rsv_flag);

    assert_plain_store_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsv_flag && cpu_st_valid && !cpu_sc_valid && !cpu_lr_valid && !soft_rst
         && !snp_hit[BUS_LOC] && !snp_hit[BUS_REM]) |=> rsv_flag);

    assert_cancel_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_rsv |-> $past(snp_hit[BUS_LOC] && !cpu_lr_valid && !soft_rst));

    assert_cancel_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_rsv |=> !cancel_rsv);

    assert_block_only_remote_sc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sc_block |-> (cpu_sc_valid && cpu_sc_remote));

    assert_lr_beats_intrusion_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_lr_valid && !soft_rst) |=> !cancel_rsv);

endmodule

// File: tb/rsv_snoop_tracker_tb.sv
module rsv_snoop_tracker_tb;

    localparam int WA_W = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst, cpu_lr_valid, cpu_lr_err, cpu_sc_valid, cpu_sc_remote, cpu_sc_aok, cpu_st_valid;
    logic [WA_W-1:0] cpu_lr_waddr, loc_wr_waddr, rem_wr_waddr;
    logic loc_wr_valid, loc_wr_aok, rem_wr_valid, rem_wr_aok;
    logic [1:0] loc_wr_size, rem_wr_size;
    logic rsv_flag, cancel_rsv, sc_block;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rsv_snoop_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .cpu_lr_valid(cpu_lr_valid), .cpu_lr_waddr(cpu_lr_waddr), .cpu_lr_err(cpu_lr_err),
        .cpu_sc_valid(cpu_sc_valid), .cpu_sc_remote(cpu_sc_remote), .cpu_sc_aok(cpu_sc_aok),
        .cpu_st_valid(cpu_st_valid),
        .loc_wr_valid(loc_wr_valid), .loc_wr_waddr(loc_wr_waddr), .loc_wr_size(loc_wr_size),
        .loc_wr_aok(loc_wr_aok),
        .rem_wr_valid(rem_wr_valid), .rem_wr_waddr(rem_wr_waddr), .rem_wr_size(rem_wr_size),
        .rem_wr_aok(rem_wr_aok),
        .rsv_flag(rsv_flag), .cancel_rsv(cancel_rsv), .sc_block(sc_block)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic clr();
        soft_rst = 0; cpu_lr_valid = 0; cpu_lr_err = 0; cpu_lr_waddr = '0;
        cpu_sc_valid = 0; cpu_sc_remote = 0; cpu_sc_aok = 0; cpu_st_valid = 0;
        loc_wr_valid = 0; loc_wr_waddr = '0; loc_wr_size = 0; loc_wr_aok = 0;
        rem_wr_valid = 0; rem_wr_waddr = '0; rem_wr_size = 0; rem_wr_aok = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_lr(input logic [WA_W-1:0] a, input logic err);
        cpu_lr_valid = 1; cpu_lr_waddr = a; cpu_lr_err = err;
        tick(); clr();
    endtask

    task automatic snoop(input bit local_bus, input logic [WA_W-1:0] a,
                         input logic [1:0] sz, input logic aok);
        if (local_bus) begin
            loc_wr_valid = 1; loc_wr_waddr = a; loc_wr_size = sz; loc_wr_aok = aok;
        end else begin
            rem_wr_valid = 1; rem_wr_waddr = a; rem_wr_size = sz; rem_wr_aok = aok;
        end
        tick(); clr();
    endtask

    task automatic t_reset();
        chk("R1 flag after hard reset", rsv_flag, 1'b0);
        chk("R1 cancel after hard reset", cancel_rsv, 1'b0);
        chk("R1 block after hard reset", sc_block, 1'b0);
        do_lr(30'h40, 0);
        soft_rst = 1; cpu_lr_valid = 1; cpu_lr_waddr = 30'h40;
        tick(); clr();
        chk("R1 soft reset clears flag", rsv_flag, 1'b0);
    endtask

    task automatic t_load_reserve();
        do_lr(30'h100, 1);
        chk("R2 flag set despite lr error", rsv_flag, 1'b1);
        do_lr(30'h200, 0);
        snoop(0, 30'h100, 2, 1);
        chk("R2 old word no longer reserved", rsv_flag, 1'b1);
        snoop(0, 30'h200, 2, 1);
        chk("R3 write to new word clears", rsv_flag, 1'b0);
    endtask

    task automatic t_sizes();
        for (int s = 0; s < 3; s++) begin
            do_lr(30'h333, 0);
            snoop(0, 30'h333, 2'(s), 1);
            chk($sformatf("R3 size %0d clears", s), rsv_flag, 1'b0);
        end
        do_lr(30'h333, 0);
        snoop(0, 30'h334, 0, 1);
        chk("R3 other word keeps", rsv_flag, 1'b1);
        snoop(0, 30'h333, 1, 0);
        chk("R3 abnormal address phase keeps", rsv_flag, 1'b1);
        snoop(1, 30'h332, 2, 1);
        chk("R3 local other word keeps", rsv_flag, 1'b1);
    endtask

    task automatic t_dword();
        do_lr(30'h101, 0);
        snoop(0, 30'h100, 3, 1);
        chk("R4 doubleword over pair clears", rsv_flag, 1'b0);
        do_lr(30'h101, 0);
        snoop(0, 30'h102, 3, 1);
        chk("R4 doubleword other pair keeps", rsv_flag, 1'b1);
        snoop(0, 30'h100, 2, 1);
        chk("R4 word write to pair partner keeps", rsv_flag, 1'b1);
    endtask

    task automatic t_store_cond();
        do_lr(30'h55, 0);
        cpu_sc_valid = 1; cpu_sc_aok = 0; tick(); clr();
        chk("R5 sc abnormal address phase keeps", rsv_flag, 1'b1);
        cpu_sc_valid = 1; cpu_sc_aok = 1; tick(); clr();
        chk("R5 sc clears", rsv_flag, 1'b0);
    endtask

    task automatic t_plain_store();
        do_lr(30'h66, 0);
        cpu_st_valid = 1; tick(); clr();
        chk("R6 plain store keeps", rsv_flag, 1'b1);
        cpu_st_valid = 1; tick(); clr();
        chk("R6 second plain store keeps", rsv_flag, 1'b1);
    endtask

    task automatic t_cancel();
        do_lr(30'h77, 0);
        chk("R7 no cancel before intrusion", cancel_rsv, 1'b0);
        snoop(1, 30'h77, 0, 1);
        chk("R7 cancel after local hit", cancel_rsv, 1'b1);
        chk("R7 flag cleared by local hit", rsv_flag, 1'b0);
        tick();
        chk("R7 cancel lasts one cycle", cancel_rsv, 1'b0);
        snoop(1, 30'h77, 0, 1);
        chk("R7 no cancel when flag clear", cancel_rsv, 1'b0);
        do_lr(30'h77, 0);
        snoop(0, 30'h77, 2, 1);
        chk("R7 no cancel for remote hit", cancel_rsv, 1'b0);
    endtask

    task automatic t_block();
        do_lr(30'h88, 0);
        snoop(0, 30'h88, 2, 1);
        cpu_sc_valid = 1; cpu_sc_remote = 1; cpu_sc_aok = 1; #1;
        chk("R8 remote sc blocked after loss", sc_block, 1'b1);
        tick(); clr();
        cpu_sc_valid = 1; cpu_sc_remote = 0; cpu_sc_aok = 1; #1;
        chk("R8 local sc not blocked", sc_block, 1'b0);
        tick(); clr();
        do_lr(30'h88, 0);
        cpu_sc_valid = 1; cpu_sc_remote = 1; cpu_sc_aok = 1; #1;
        chk("R8 remote sc with flag set passes", sc_block, 1'b0);
        tick(); clr();
    endtask

    task automatic t_lr_vs_local();
        do_lr(30'h99, 0);
        cpu_lr_valid = 1; cpu_lr_waddr = 30'hA0;
        loc_wr_valid = 1; loc_wr_waddr = 30'h99; loc_wr_size = 2; loc_wr_aok = 1;
        tick(); clr();
        chk("R9 new reservation wins", rsv_flag, 1'b1);
        chk("R9 no cancel on reload", cancel_rsv, 1'b0);
    endtask

    task automatic t_sc_vs_remote();
        do_lr(30'hB0, 0);
        cpu_sc_valid = 1; cpu_sc_remote = 1; cpu_sc_aok = 0;
        rem_wr_valid = 1; rem_wr_waddr = 30'hB0; rem_wr_size = 2; rem_wr_aok = 1;
        #1;
        chk("R10 same-cycle sc not blocked", sc_block, 1'b0);
        tick(); clr();
        chk("R10 flag clear after collision", rsv_flag, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        clr();
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1;
        tick();
        t_reset();
        t_load_reserve();
        t_sizes();
        t_dword();
        t_store_cond();
        t_plain_store();
        t_cancel();
        t_block();
        t_lr_vs_local();
        t_sc_vs_remote();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule